// File: doc/BRIEF.md
# Indirect 64-bit Register Access Bridge

This bridge gives a host on a narrow 32-bit register bus access to an internal space of 64-bit registers. The host sees a small window of six locations: two 32-bit staging words, a command word, a reset strobe, a status word and an interrupt enable. All internal traffic goes through this window.

To write an internal register, the host loads the upper half into staging word 0 and the lower half into staging word 1. It then writes the command word with bit 31 set. The bridge places the joined 64-bit value on its internal port. To read, the host writes the command word with bit 31 clear. When the operation finishes, the fetched value is held with its upper half in staging word 0 and its lower half in staging word 1.

Each accepted command runs a request/acknowledge handshake on the internal port. The host polls a busy bit in the status word until the command completes. It then checks the sticky error bit, which holds until a write to the reset location clears it.

Top module: `ind64_bridge`

## Requirements
- R1: The window decodes byte offsets 0x00 (staging word 0), 0x04 (staging word 1), 0x08 (command), 0x18 (error clear), 0x1C (status) and 0x20 (interrupt enable). After reset, every readable location returns zero and `int_req` and `irq` are low.
- R2: A command word with bit 31 set writes the internal register at address bits 15:0. The write data is {staging word 0, staging word 1}, so word 0 supplies bits 63:32.
- R3: A command word with bit 31 clear reads the internal register at address bits 15:0. On completion, staging word 0 holds bits 63:32 of the result and staging word 1 holds bits 31:0.
- R4: Status bit 0 (busy) and `int_req` are high from the clock edge that accepts a command until the edge that samples `int_ack`. While the request waits, address, write enable and write data stay constant.
- R5: Host writes to the staging words while busy have no effect.
- R6: A command written while busy is discarded: the running access continues unchanged and status bit 31 (error) is set.
- R7: A command with any of bits 30:16 nonzero sets the error bit and starts no internal access.
- R8: An internal access that completes with `int_err` high sets the error bit. If that access is a read, the staging words are left unchanged.
- R9: The error bit is sticky. Only a write of any value to offset 0x18 clears it.
- R10: Bit 0 of the interrupt-enable location (0x20) is readable and writable, and `irq` equals error AND enable.
- R11: Offset 0x08 reads back the last command written while idle. Any unmapped offset reads as zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_sel | input | 1 | Host access strobe, one cycle per access |
| h_wr | input | 1 | Host access is a write |
| h_addr | input | 8 | Host byte offset into the window |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, combinational from h_addr |
| int_req | output | 1 | Internal access request, held until acknowledged |
| int_we | output | 1 | Internal access is a write |
| int_addr | output | 16 | Internal register address |
| int_wdata | output | 64 | Internal write data |
| int_ack | input | 1 | Internal access complete |
| int_rdata | input | 64 | Internal read data, valid with int_ack |
| int_err | input | 1 | Internal access failed, valid with int_ack |
| irq | output | 1 | Error interrupt |

## Verification
Some properties hold on every cycle and are checked by assertions:
- the request holds stable until it is acknowledged and drops right after the acknowledge;
- a bad address or an overlapping command raises the error bit and leaves the request untouched;
- the error bit is sticky, and `irq` never rises without it.

Other behaviours need full host sequences, so only the bench scenarios show them:
- round trips of 64-bit values through the staging words, in high-then-low order, under several acknowledge latencies;
- staging writes ignored while busy;
- staging words preserved after a failed read;
- command readback and the unmapped offsets.

// File: rtl/ind64_bridge.sv
module ind64_bridge #(
  parameter int HAW = 8,
  parameter int DW  = 32,
  parameter int IAW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_sel,
  input  logic             h_wr,
  input  logic [HAW-1:0]   h_addr,
  input  logic [DW-1:0]    h_wdata,
  output logic [DW-1:0]    h_rdata,
  output logic             int_req,
  output logic             int_we,
  output logic [IAW-1:0]   int_addr,
  output logic [2*DW-1:0]  int_wdata,
  input  logic             int_ack,
  input  logic [2*DW-1:0]  int_rdata,
  input  logic             int_err,
  output logic             irq
);
  localparam int RW = 2*DW;
  localparam logic [HAW-1:0] OFF_D0  = HAW'(8'h00);
  localparam logic [HAW-1:0] OFF_D1  = HAW'(8'h04);
  localparam logic [HAW-1:0] OFF_CMD = HAW'(8'h08);
  localparam logic [HAW-1:0] OFF_CLR = HAW'(8'h18);
  localparam logic [HAW-1:0] OFF_STS = HAW'(8'h1C);
  localparam logic [HAW-1:0] OFF_IEN = HAW'(8'h20);

  logic [DW-1:0] stg_hi, stg_lo, cmd_q;
  logic          busy_q, err_q, ien_q;

  wire host_wr  = h_sel & h_wr;
  wire cmd_wr   = host_wr && (h_addr == OFF_CMD);
  wire clr_wr   = host_wr && (h_addr == OFF_CLR);
  wire addr_bad = |h_wdata[DW-2:IAW];
  wire accept   = cmd_wr && !busy_q && !addr_bad;
  wire finish   = busy_q && int_ack;
  wire err_set  = (cmd_wr && (busy_q || addr_bad)) || (finish && int_err);
  wire rd_load  = finish && !cmd_q[DW-1] && !int_err;

  assign int_req   = busy_q;
  assign int_we    = cmd_q[DW-1];
  assign int_addr  = cmd_q[IAW-1:0];
  assign int_wdata = {stg_hi, stg_lo};
  assign irq       = err_q & ien_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_hi <= '0;
      stg_lo <= '0;
      cmd_q  <= '0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      if (accept)      busy_q <= 1'b1;
      else if (finish) busy_q <= 1'b0;

      if (cmd_wr && !busy_q) cmd_q <= h_wdata;

      if (rd_load)
        stg_hi <= int_rdata[RW-1:DW];
      else if (host_wr && !busy_q && h_addr == OFF_D0)
        stg_hi <= h_wdata;

      if (rd_load)
        stg_lo <= int_rdata[DW-1:0];
      else if (host_wr && !busy_q && h_addr == OFF_D1)
        stg_lo <= h_wdata;

      if (err_set)     err_q <= 1'b1;
      else if (clr_wr) err_q <= 1'b0;

      if (host_wr && h_addr == OFF_IEN) ien_q <= h_wdata[0];
    end
  end

  always_comb begin
    h_rdata = '0;
    case (h_addr)
      OFF_D0:  h_rdata = stg_hi;
      OFF_D1:  h_rdata = stg_lo;
      OFF_CMD: h_rdata = cmd_q;
      OFF_STS: begin
        h_rdata[DW-1] = err_q;
        h_rdata[0]    = busy_q;
      end
      OFF_IEN: h_rdata[0] = ien_q;
      default: h_rdata = '0;
    endcase
  end

  // R4: pending request keeps its attributes
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    int_req && !int_ack |=> int_req && $stable(int_addr) && $stable(int_we) && $stable(int_wdata));

  // R4: request drops right after the acknowledge
  a_r4_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    int_req && int_ack |=> !int_req);

  // R6: overlapping command leaves the running access alone
  a_r6_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && int_req && !int_ack |=> int_req && $stable(int_addr) && $stable(int_we) && err_q);

  // R7: out-of-range address starts nothing
  a_r7_bad_addr: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !int_req && addr_bad |=> !int_req && err_q);

  // R9: error holds until the clear location is written
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !clr_wr |=> err_q);

  // R10: interrupt implies a pending error
  a_r10_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> err_q);
endmodule

// File: tb/sim_ind64_bridge.sv
`timescale 1ns/1ps
module sim_ind64_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_sel = 1'b0, h_wr = 1'b0;
  logic [7:0]  h_addr = '0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic        int_req, int_we, int_ack, int_err, irq;
  logic [15:0] int_addr;
  logic [63:0] int_wdata, int_rdata;

  int checks = 0, fails = 0, lat = 0, cnt = 0;
  logic [63:0] mem [16];
  logic        ack_q;

  always #2.5 clk = ~clk;

  ind64_bridge u0 (
    .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .int_req(int_req), .int_we(int_we),
    .int_addr(int_addr), .int_wdata(int_wdata), .int_ack(int_ack),
    .int_rdata(int_rdata), .int_err(int_err), .irq(irq)
  );

  assign int_ack   = ack_q;
  assign int_rdata = mem[int_addr[3:0]];
  assign int_err   = (int_addr[15:8] == 8'hEE);

  always @(posedge clk) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      cnt   <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else if (ack_q) begin
      ack_q <= 1'b0;
      cnt   <= 0;
      if (int_req && int_we && !int_err) mem[int_addr[3:0]] <= int_wdata;
    end else if (int_req) begin
      if (cnt >= lat) ack_q <= 1'b1;
      else cnt <= cnt + 1;
    end
  end

  localparam int NV = 6;
  localparam logic [87:0] VEC [NV] = '{
    {16'h0001, 64'h0123_4567_89AB_CDEF, 8'd0},
    {16'h0002, 64'hFFFF_FFFF_0000_0000, 8'd1},
    {16'h0005, 64'h0000_0000_FFFF_FFFF, 8'd3},
    {16'h00A7, 64'hDEAD_BEEF_CAFE_F00D, 8'd7},
    {16'h0F0C, 64'h8000_0000_0000_0001, 8'd2},
    {16'hFFFE, 64'h5A5A_A5A5_3C3C_C3C3, 8'd12}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    h_sel = 1'b1; h_wr = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_sel = 1'b0; h_wr = 1'b0;
  endtask

  task automatic hr(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    h_sel = 1'b1; h_wr = 1'b0; h_addr = a;
    #1 d = h_rdata;
    h_sel = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 200; k++) begin
      hr(8'h1C, s);
      if (!s[0]) return;
    end
  endtask

  logic [31:0] r, r2;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    hr(8'h00, r); check("R1 d0", {32'd0, r}, 64'd0);
    hr(8'h04, r); check("R1 d1", {32'd0, r}, 64'd0);
    hr(8'h1C, r); check("R1 status", {32'd0, r}, 64'd0);
    hr(8'h20, r); check("R1 ien", {32'd0, r}, 64'd0);
    check("R1 req/irq", {62'd0, int_req, irq}, 64'd0);

    // R2 R3: table of round trips
    for (int v = 0; v < NV; v++) begin
      lat = int'(VEC[v][7:0]);
      hw(8'h00, VEC[v][71:40]);
      hw(8'h04, VEC[v][39:8]);
      hw(8'h08, {1'b1, 15'd0, VEC[v][87:72]});
      hr(8'h1C, r); check("R4 busy after write cmd", {63'd0, r[0]}, 64'd1);
      wait_idle();
      check("R2 target written", mem[VEC[v][75:72]], VEC[v][71:8]);
      hw(8'h00, 32'h0); hw(8'h04, 32'h0);
      hw(8'h08, {16'd0, VEC[v][87:72]});
      wait_idle();
      hr(8'h00, r); hr(8'h04, r2);
      check("R3 read back hi/lo", {r, r2}, VEC[v][71:8]);
      hr(8'h1C, r); check("R8 no error on good access", {32'd0, r}, 64'd0);
    end

    // R7: out of range address
    hw(8'h08, 32'h0001_0003);
    hr(8'h1C, r); check("R7 error, not busy", {32'd0, r}, 64'h8000_0000);
    check("R7 no request", {63'd0, int_req}, 64'd0);
    hw(8'h18, 32'h0);
    hr(8'h1C, r); check("R9 clear", {32'd0, r}, 64'd0);

    // R5 R6: activity while busy
    lat = 20;
    hw(8'h00, 32'h1111_2222); hw(8'h04, 32'h3333_4444);
    hw(8'h08, 32'h8000_0003);
    hw(8'h08, 32'h0000_0004);
    hw(8'h00, 32'hFFFF_FFFF);
    hr(8'h00, r); check("R5 staging held", {32'd0, r}, 64'h1111_2222);
    hr(8'h1C, r); check("R6 error while busy", {32'd0, r}, 64'h8000_0001);
    wait_idle();
    check("R6 first command completed", mem[3], 64'h1111_2222_3333_4444);
    check("R6 second command dropped", mem[4], 64'd0);
    hr(8'h08, r); check("R11 cmd readback", {32'd0, r}, 64'h8000_0003);
    hr(8'h1C, r); check("R9 sticky", {32'd0, r}, 64'h8000_0000);
    hw(8'h18, 32'h0);

    // R8 R10: internal error on a read
    lat = 1;
    hw(8'h08, 32'h0000_EE05);
    wait_idle();
    hr(8'h1C, r); check("R8 error set", {32'd0, r}, 64'h8000_0000);
    hr(8'h00, r); hr(8'h04, r2);
    check("R8 staging unchanged", {r, r2}, 64'h1111_2222_3333_4444);
    check("R10 irq off when disabled", {63'd0, irq}, 64'd0);
    hw(8'h20, 32'h1);
    hr(8'h20, r); check("R10 enable readback", {32'd0, r}, 64'd1);
    check("R10 irq on", {63'd0, irq}, 64'd1);
    hw(8'h18, 32'hABCD);
    check("R9 irq cleared with error", {63'd0, irq}, 64'd0);
    hr(8'h1C, r); check("R9 status clear", {32'd0, r}, 64'd0);

    // R11: unmapped offsets
    hw(8'h0C, 32'h1234_5678);
    hr(8'h0C, r); check("R11 unmapped reads 0", {32'd0, r}, 64'd0);
    hr(8'h00, r); check("R11 unmapped write no effect", {32'd0, r}, 64'h1111_2222);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule